// File: doc/BRIEF.md
# Serial Transmit Engine with Selectable Interrupt Trigger

This block is the transmit half of an asynchronous serial port. Software places 8-bit characters into a four-entry holding queue through a simple write strobe. A shift stage takes characters from the queue and sends them as frames: one start bit, eight data bits with the least significant bit first, and one stop bit. There is no parity. Bit timing comes from an external baud tick, and each bit lasts exactly one tick period. A frame always begins on a tick.

A two-bit mode input selects when the single-cycle interrupt pulse fires: on every hand-off from the queue to the shifter, only on the hand-off that drains the queue, or when all transmission has finished. A break request sends a long low pulse in place of the next frame and then clears itself. An invert input flips the line polarity. Dropping the enable aborts the frame in progress and flushes the queue.

Top module: `uart_tx_core`

## Requirements
- R1: Idle state after reset.
  - `txd` is 1.
  - `buf_full` is 0.
  - `shifter_empty` is 1.
  - `tx_irq` is 0.
  - `brk_busy` is 0.
- R2: Frame format and timing.
  - A frame starts at the clock edge where `baud_tick` is high.
  - Bit order on `txd` is: start bit 0, then `wr_data` bits 0 to 7, then stop bit 1.
  - Every bit is held until the next tick.
  - When the queue still holds characters, the next frame starts at the tick that ends the stop bit, with no idle gap.
- R3: Holding queue.
  - The queue holds 4 characters and sends them in first-in, first-out order.
  - A write is accepted only when fewer than 4 characters are held at that clock edge. Any other write is dropped.
  - `buf_full` is 1 exactly when 4 characters are held.
- R4: `shifter_empty` is 1 only when no frame is active and the queue is empty.
- R5: With `irq_mode` = 2'b00, `tx_irq` pulses once for every character that moves from the queue into the shifter.
- R6: With `irq_mode` = 2'b10, `tx_irq` pulses only when a character moves into the shifter and that transfer leaves the queue empty.
- R7: With `irq_mode` = 2'b01, `tx_irq` pulses when a frame ends and there is no queued character or break to send next.
- R8: With `irq_mode` = 2'b11, `tx_irq` never pulses.
- R9: Break frames.
  - A one-cycle `brk_set` (while enabled) sets the break request, which is shown on `brk_busy`.
  - The next frame to start is a break frame instead of a queued character: a start bit, twelve 0 bits, then a 1 stop bit, for 14 ticks in total.
  - `brk_busy` clears when that frame ends.
  - A break hand-off is not a character transfer for R5 and R6.
- R10: Disable and abort.
  - While `tx_en` is 0, the block is held with the active frame aborted, the queue and break request cleared, and `txd` at the idle level.
  - Writes and `brk_set` are ignored while `tx_en` is 0.
- R11: Polarity inversion.
  - With `tx_inv` = 1 the line idles at 0.
  - Every transmitted bit is the inverse of its R2 value.
- R12: Interrupt pulse timing. `tx_irq` is high for exactly one clock, in the cycle right after the clock edge of the triggering event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; 0 aborts the frame and flushes the queue |
| irq_mode | input | 2 | Interrupt trigger select (00 per transfer, 10 on drain, 01 on completion, 11 none) |
| tx_inv | input | 1 | Line polarity inversion |
| brk_set | input | 1 | One-cycle strobe that requests a break frame |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to queue |
| txd | output | 1 | Serial line |
| buf_full | output | 1 | Queue holds 4 characters |
| shifter_empty | output | 1 | No frame active and queue empty |
| brk_busy | output | 1 | Break request pending or being sent |
| tx_irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The hardest case to reach is the interaction between hand-offs at the tick that ends a stop bit. In that case one frame's completion and the next frame's load happen on the same edge. The completion interrupt must stay quiet, and the drain interrupt must fire only on the final load.

The bench writes several characters with no ticks running, so that the queue is pre-loaded. It then steps ticks one at a time and decodes each frame bit by bit. This creates back-to-back frames, including a break followed directly by a data frame. The bench counts interrupt pulses for each mode over the whole burst.

A separate scenario removes the enable part-way through a frame. It then tries a write while disabled, and checks that no frame or pulse appears after re-enabling.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    IRQ_PER_LOAD = 2'b00,
    IRQ_ALL_DONE = 2'b01,
    IRQ_ON_DRAIN = 2'b10,
    IRQ_QUIET    = 2'b11
  } irq_mode_e;

  localparam int unsigned BRK_ZERO_BITS = 12;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          not_empty,
  output logic          empty_nx,
  output logic          full_nx
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_d, rp_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (cnt != CW'(DEPTH)) && !flush;
  assign pop_ok  = pop && (cnt != '0) && !flush;

  always_comb begin
    wp_d  = wp;
    rp_d  = rp;
    cnt_d = cnt;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = adv(wp);
      if (pop_ok)  rp_d = adv(rp);
      cnt_d = cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_d;
      rp  <= rp_d;
      cnt <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  assign dout      = mem[rp];
  assign not_empty = (cnt != '0);
  assign empty_nx  = (cnt_d == '0);
  assign full_nx   = (cnt_d == CW'(DEPTH));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int unsigned DW        = 8,
  parameter int unsigned BRK_ZEROS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          tick,
  input  logic          load_data,
  input  logic          load_brk,
  input  logic [DW-1:0] data,
  output logic          line,
  output logic          busy,
  output logic          last
);
  localparam int unsigned DLEN = DW + 2;
  localparam int unsigned BLEN = BRK_ZEROS + 2;
  localparam int unsigned SW   = (DLEN > BLEN) ? DLEN : BLEN;
  localparam int unsigned RW   = $clog2(SW + 1);

  logic [SW-1:0] sh, sh_d, data_frame, brk_frame;
  logic [RW-1:0] rem, rem_d;

  assign data_frame = ({SW{1'b1}} << (DW + 1)) | SW'({data, 1'b0});
  assign brk_frame  = {SW{1'b1}} << (BRK_ZEROS + 1);

  assign busy = (rem != '0);
  assign last = tick && (rem == RW'(1));

  always_comb begin
    sh_d  = sh;
    rem_d = rem;
    if (abort) begin
      sh_d  = '1;
      rem_d = '0;
    end else if (tick) begin
      if (load_data) begin
        sh_d  = data_frame;
        rem_d = RW'(DLEN);
      end else if (load_brk) begin
        sh_d  = brk_frame;
        rem_d = RW'(BLEN);
      end else if (busy) begin
        sh_d  = {1'b1, sh[SW-1:1]};
        rem_d = rem - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '1;
      rem <= '0;
    end else begin
      sh  <= sh_d;
      rem <= rem_d;
    end
  end

  assign line = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode,
  input  logic      ev_load,
  input  logic      ev_drain,
  input  logic      ev_done,
  output logic      irq
);
  logic irq_d;

  always_comb begin
    unique case (mode)
      IRQ_PER_LOAD: irq_d = ev_load;
      IRQ_ON_DRAIN: irq_d = ev_drain;
      IRQ_ALL_DONE: irq_d = ev_done;
      default:      irq_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic [1:0]    irq_mode,
  input  logic          tx_inv,
  input  logic          brk_set,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic          buf_full,
  output logic          shifter_empty,
  output logic          brk_busy,
  output logic          tx_irq
);
  logic [DW-1:0] q_dout;
  logic q_ne, q_empty_nx, q_full_nx;
  logic sh_line, sh_busy, sh_last;
  logic brk_pend, brk_pend_d, cur_brk, cur_brk_d;
  logic full_q, empty_q, busy_nx;
  logic brk_ready, load, load_brk, char_load, done;

  assign brk_ready = brk_pend && !(sh_busy && cur_brk);
  assign load      = tx_en && baud_tick && (brk_ready || q_ne) && (!sh_busy || sh_last);
  assign load_brk  = load && brk_ready;
  assign char_load = load && !brk_ready;
  assign done      = tx_en && sh_last && !load;
  assign busy_nx   = tx_en && (load || (sh_busy && !sh_last));

  uart_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en),
    .push(wr_en), .din(wr_data), .pop(char_load),
    .dout(q_dout), .not_empty(q_ne), .empty_nx(q_empty_nx), .full_nx(q_full_nx)
  );

  uart_tx_shift #(.DW(DW), .BRK_ZEROS(BRK_ZERO_BITS)) shift_i (
    .clk(clk), .rst_n(rst_n), .abort(!tx_en), .tick(baud_tick),
    .load_data(char_load), .load_brk(load_brk), .data(q_dout),
    .line(sh_line), .busy(sh_busy), .last(sh_last)
  );

  uart_tx_irq irq_i (
    .clk(clk), .rst_n(rst_n), .mode(irq_mode_e'(irq_mode)),
    .ev_load(char_load), .ev_drain(char_load && q_empty_nx), .ev_done(done),
    .irq(tx_irq)
  );

  always_comb begin
    brk_pend_d = brk_pend;
    cur_brk_d  = cur_brk;
    if (!tx_en) begin
      brk_pend_d = 1'b0;
      cur_brk_d  = 1'b0;
    end else begin
      if (sh_last && cur_brk) brk_pend_d = 1'b0;
      if (brk_set)            brk_pend_d = 1'b1;
      if (load)               cur_brk_d  = brk_ready;
      else if (sh_last)       cur_brk_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_pend <= 1'b0;
      cur_brk  <= 1'b0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      brk_pend <= brk_pend_d;
      cur_brk  <= cur_brk_d;
      full_q   <= q_full_nx;
      empty_q  <= !busy_nx && q_empty_nx;
    end
  end

  assign txd           = sh_line ^ tx_inv;
  assign buf_full      = full_q;
  assign shifter_empty = empty_q;
  assign brk_busy      = brk_pend;
endmodule

module uart_tx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic [1:0] irq_mode,
  input logic       tx_inv,
  input logic       txd,
  input logic       buf_full,
  input logic       shifter_empty,
  input logic       brk_busy,
  input logic       tx_irq
);
  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shifter_empty |-> (txd == !tx_inv));
  assert_full_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !shifter_empty);
  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (shifter_empty && !buf_full && !brk_busy));
  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b11) |=> !tx_irq);
  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
endmodule

bind uart_tx_core uart_tx_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_mode(irq_mode), .tx_inv(tx_inv),
  .txd(txd), .buf_full(buf_full), .shifter_empty(shifter_empty),
  .brk_busy(brk_busy), .tx_irq(tx_irq)
);

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic [1:0] irq_mode = 2'b00;
  logic tx_inv = 1'b0;
  logic brk_set = 1'b0;
  logic baud_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, buf_full, shifter_empty, brk_busy, tx_irq;

  int checks = 0;
  int failures = 0;
  int irq_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_tx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_mode(irq_mode), .tx_inv(tx_inv),
    .brk_set(brk_set), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .buf_full(buf_full), .shifter_empty(shifter_empty),
    .brk_busy(brk_busy), .tx_irq(tx_irq)
  );

  always @(posedge clk) if (tx_irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_tick(output logic b);
    @(negedge clk);
    b = txd;
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  endtask

  task automatic recv(input int n, input bit lead, output logic [15:0] bits);
    logic b;
    bits = '0;
    if (lead) do_tick(b);
    for (int i = 0; i < n; i++) begin
      do_tick(b);
      bits[i] = b;
    end
  endtask

  task automatic write_chr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] dframe(input logic [7:0] d);
    return {6'b0, 1'b1, d, 1'b0};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 shifter_empty", shifter_empty, 1);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 brk_busy", brk_busy, 0);
  endtask

  task automatic t_single;
    logic [15:0] bits;
    int base;
    irq_mode = 2'b00;
    base = irq_cnt;
    write_chr(8'hA5);
    @(negedge clk);
    chk("R4 empty low while queued", shifter_empty, 0);
    recv(10, 1'b1, bits);
    chk("R2 frame A5", bits, dframe(8'hA5));
    @(negedge clk);
    chk("R4 empty after frame", shifter_empty, 1);
    chk("R5 one pulse", irq_cnt - base, 1);
  endtask

  task automatic t_fill;
    logic [15:0] bits;
    int base;
    irq_mode = 2'b00;
    base = irq_cnt;
    write_chr(8'h11);
    write_chr(8'h22);
    write_chr(8'h33);
    @(negedge clk);
    chk("R3 not full at 3", buf_full, 0);
    write_chr(8'h44);
    @(negedge clk);
    chk("R3 full at 4", buf_full, 1);
    write_chr(8'h55);
    recv(10, 1'b1, bits);
    chk("R3 first 11", bits, dframe(8'h11));
    chk("R3 full clears", buf_full, 0);
    recv(10, 1'b0, bits);
    chk("R2 back-to-back 22", bits, dframe(8'h22));
    recv(10, 1'b0, bits);
    chk("R3 third 33", bits, dframe(8'h33));
    recv(10, 1'b0, bits);
    chk("R3 fourth 44 (55 dropped)", bits, dframe(8'h44));
    @(negedge clk);
    chk("R3 nothing after 44", shifter_empty, 1);
    chk("R5 four pulses", irq_cnt - base, 4);
  endtask

  task automatic t_mode(input logic [1:0] m, input int exp_pulses, input string tag);
    logic [15:0] bits;
    int base;
    irq_mode = m;
    base = irq_cnt;
    write_chr(8'h3C);
    write_chr(8'hC3);
    recv(10, 1'b1, bits);
    recv(10, 1'b0, bits);
    chk({tag, " second frame"}, bits, dframe(8'hC3));
    repeat (3) @(negedge clk);
    chk({tag, " pulse count"}, irq_cnt - base, exp_pulses);
  endtask

  task automatic t_pulse_timing;
    logic b;
    int base;
    irq_mode = 2'b00;
    write_chr(8'h01);
    base = irq_cnt;
    @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    chk("R12 irq high after load edge", tx_irq, 1);
    @(negedge clk);
    chk("R12 irq one cycle", tx_irq, 0);
    for (int i = 0; i < 10; i++) do_tick(b);
    chk("R12 one pulse total", irq_cnt - base, 1);
  endtask

  task automatic t_break;
    logic [15:0] bits;
    int base;
    irq_mode = 2'b00;
    base = irq_cnt;
    @(negedge clk);
    brk_set = 1'b1;
    @(negedge clk);
    brk_set = 1'b0;
    chk("R9 busy set", brk_busy, 1);
    write_chr(8'h5A);
    recv(14, 1'b1, bits);
    chk("R9 break bits", bits, 16'h2000);
    chk("R9 busy cleared", brk_busy, 0);
    recv(10, 1'b0, bits);
    chk("R9 data after break", bits, dframe(8'h5A));
    @(negedge clk);
    chk("R9 break not a transfer", irq_cnt - base, 1);
  endtask

  task automatic t_invert;
    logic [15:0] bits;
    tx_inv = 1'b1;
    @(negedge clk);
    chk("R11 idle low", txd, 0);
    write_chr(8'h96);
    recv(10, 1'b1, bits);
    chk("R11 inverted frame", bits, dframe(8'h96) ^ 16'h03FF);
    tx_inv = 1'b0;
  endtask

  task automatic t_abort;
    logic [15:0] bits;
    logic b;
    int base;
    irq_mode = 2'b00;
    write_chr(8'h00);
    write_chr(8'h00);
    write_chr(8'h00);
    recv(3, 1'b1, bits);
    @(negedge clk);
    brk_set = 1'b1;
    @(negedge clk);
    brk_set = 1'b0;
    tx_en = 1'b0;
    @(negedge clk);
    chk("R10 line idle", txd, 1);
    chk("R10 empty", shifter_empty, 1);
    chk("R10 not full", buf_full, 0);
    chk("R10 break dropped", brk_busy, 0);
    write_chr(8'h00);
    @(negedge clk);
    brk_set = 1'b1;
    @(negedge clk);
    brk_set = 1'b0;
    chk("R10 brk_set ignored", brk_busy, 0);
    tx_en = 1'b1;
    base = irq_cnt;
    @(negedge clk);
    chk("R10 write ignored", shifter_empty, 1);
    bits = '0;
    for (int i = 0; i < 12; i++) begin
      do_tick(b);
      bits[i] = b;
    end
    chk("R10 no frame after re-enable", bits, 16'h0FFF);
    chk("R10 no pulse", irq_cnt - base, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    tx_en = 1'b1;
    t_single();
    t_fill();
    t_mode(2'b10, 1, "R6 drain");
    t_mode(2'b01, 1, "R7 done");
    t_mode(2'b11, 0, "R8 reserved");
    t_pulse_timing();
    t_break();
    t_invert();
    t_abort();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule